// File: doc/BRIEF.md
# Shared Mailbox Hub

The hub gives several agents on one chip a small set of one-word message slots and a way to be told when a slot needs attention. Each slot holds a 32-bit word. The top bit of that word is the "occupied" flag, and the remaining 31 bits are the payload. A sender writes a payload with the flag set. A receiver drains the slot by writing zero to the whole word, which clears the payload and the flag together.

The block derives a per-slot occupied bit and a per-slot vacant bit from the slot words and gathers them into one read-only status word. Each interrupt output has its own enable word with the same bit layout as the status word. An output is high for as long as any status bit that is both enabled for that line and admitted by the slot's own gate bits is set. Nothing is latched, so the outputs are purely level based.

When the per-slot gates are built, each slot has one gate bit for the occupied condition and one for the vacant condition. A read-only capability word reports how many units of each kind the build contains. Access uses a plain register port with separate write and read strobes. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `shmbox_hub`

## Requirements
- R1: After reset, every slot word reads 0, every gate bit and line enable reads 0, the status word reads 0x0000000F in the default build, and every interrupt output is low. An asynchronous reset in the middle of a run returns the block to this state.
- R2: A write to a slot word (slot k at byte address 0x20*k) stores all 32 bits, and reading the word back returns them. The slot is occupied exactly when bit 31 of the stored word is 1. A payload written with bit 31 clear leaves the slot vacant.
- R3: Writing 0x00000000 to an occupied slot word makes the slot vacant and its payload zero from the next cycle on.
- R4: The status word at 0x304 is read-only. Bit k is 1 when slot k is vacant, and bit 8+k is 1 when slot k is occupied. Bits for slots that are not built, and bits 31:16, read as 0. A write to 0x304 changes nothing.
- R5: Line n has an enable word at 0x100 + 4*n. Only bits that match a built slot's vacant or occupied bit are stored; all other bits read as 0. Addresses for lines that are not built ignore writes and read as 0.
- R6: Interrupt output n is high in every cycle in which some bit is set in all three of: the status word, line n's enable word, and the matching slot gate. It stays high without any edge while that holds, and drops once the condition clears.
- R7: Each slot has an occupied-gate bit (bit 0 of slot word address + 0x04) and a vacant-gate bit (bit 0 of slot address + 0x08). A line-enabled status bit whose gate is 0 does not raise any output.
- R8: The capability word at 0x380 is read-only. It holds 4-bit counts: slots in bits 3:0, shared semaphores in 7:4, arbitrated semaphores in 11:8, doorbells in 15:12, and interrupt lines in 19:16. In the default build it reads 0x00025234.
- R9: rd_data takes the addressed value in the cycle after a cycle with rd_en high, and keeps its value while rd_en is low. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Read data, registered |
| irq | output | NUM_LINE | Level interrupt outputs, one per line |

## Verification
The bench builds the hub with its default parameters: four slots, two interrupt lines and the per-slot gates present. With this build, the status bits for slots four to seven exist in the layout but must read as zero, the enable address of a third line lies inside the line window yet has no storage behind it, and both lines can be driven from the same status bit through different gates. A slot carrying a payload without its flag, a forbidden write to the status word, and a reset in the middle of a run with full slots all fall within reach.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned BOX_MAX  = 8;
  localparam int unsigned LINE_MAX = 16;
  localparam int unsigned STAT_W   = 2 * BOX_MAX;

  localparam logic [ADDR_W-1:0] LINE_EN_BASE = 12'h100;
  localparam logic [ADDR_W-1:0] STATUS_ADDR  = 12'h304;
  localparam logic [ADDR_W-1:0] CAP_ADDR     = 12'h380;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SLOT,
    SEL_LINE,
    SEL_STATUS,
    SEL_CAP
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [2:0] slot;
    logic [1:0] field;
    logic [3:0] line;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                  input int unsigned nbox,
                                  input int unsigned nline);
    dec_t d;
    d.sel   = SEL_NONE;
    d.slot  = a[7:5];
    d.field = a[3:2];
    d.line  = a[5:2];
    if (a[1:0] == 2'b00) begin
      if (a < ADDR_W'(nbox * 32)) begin
        if (a[4:2] <= 3'd2) d.sel = SEL_SLOT;
      end else if ((a >= LINE_EN_BASE) && (a < LINE_EN_BASE + ADDR_W'(nline * 4))) begin
        d.sel = SEL_LINE;
      end else if (a == STATUS_ADDR) begin
        d.sel = SEL_STATUS;
      end else if (a == CAP_ADDR) begin
        d.sel = SEL_CAP;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/shmbox_slot.sv
module shmbox_slot #(
  parameter bit PER_BOX_IE = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_we,
  input  logic                         ief_we,
  input  logic                         iee_we,
  input  logic [shmbox_pkg::WORD_W-1:0] wdata,
  output logic [shmbox_pkg::WORD_W-1:0] word_q,
  output logic                         gate_full,
  output logic                         gate_empty,
  output logic                         ief_rd,
  output logic                         iee_rd
);
  logic [shmbox_pkg::WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (word_we) word_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_we) word_q <= word_d;
  end

  if (PER_BOX_IE) begin : g_gates
    logic ief_q, iee_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ief_q <= 1'b0;
      else if (ief_we) ief_q <= wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      iee_q <= 1'b0;
      else if (iee_we) iee_q <= wdata[0];
    end

    assign gate_full  = ief_q;
    assign gate_empty = iee_q;
    assign ief_rd     = ief_q;
    assign iee_rd     = iee_q;
  end else begin : g_open
    logic unused_gate_we;
    assign unused_gate_we = ief_we ^ iee_we;
    assign gate_full  = 1'b1;
    assign gate_empty = 1'b1;
    assign ief_rd     = 1'b0;
    assign iee_rd     = 1'b0;
  end
endmodule

// File: rtl/shmbox_irq_agg.sv
module shmbox_irq_agg #(
  parameter int unsigned NUM_BOX  = 4,
  parameter int unsigned NUM_LINE = 2
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic [NUM_BOX-1:0]                              full_vec,
  input  logic [NUM_BOX-1:0]                              gate_full,
  input  logic [NUM_BOX-1:0]                              gate_empty,
  input  logic [NUM_LINE-1:0]                             en_we,
  input  logic [shmbox_pkg::STAT_W-1:0]                   wdata,
  output logic [shmbox_pkg::STAT_W-1:0]                   status,
  output logic [NUM_LINE-1:0][shmbox_pkg::STAT_W-1:0]     line_en,
  output logic [NUM_LINE-1:0]                             irq
);
  import shmbox_pkg::*;

  localparam logic [BOX_MAX-1:0] BOX_MASK   = BOX_MAX'((1 << NUM_BOX) - 1);
  localparam logic [STAT_W-1:0]  VALID_MASK = {BOX_MASK, BOX_MASK};

  logic [STAT_W-1:0] gated;

  for (genvar i = 0; i < BOX_MAX; i++) begin : g_bit
    if (i < NUM_BOX) begin : g_live
      assign status[i]           = ~full_vec[i];
      assign status[BOX_MAX + i] = full_vec[i];
      assign gated[i]            = ~full_vec[i] & gate_empty[i];
      assign gated[BOX_MAX + i]  = full_vec[i] & gate_full[i];
    end else begin : g_pad
      assign status[i]           = 1'b0;
      assign status[BOX_MAX + i] = 1'b0;
      assign gated[i]            = 1'b0;
      assign gated[BOX_MAX + i]  = 1'b0;
    end
  end

  for (genvar n = 0; n < NUM_LINE; n++) begin : g_line
    logic [STAT_W-1:0] en_d;

    always_comb begin
      en_d = line_en[n];
      if (en_we[n]) en_d = wdata & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         line_en[n] <= '0;
      else if (en_we[n])  line_en[n] <= en_d;
    end

    assign irq[n] = |(gated & line_en[n]);
  end
endmodule

// File: rtl/shmbox_hub.sv
module shmbox_hub #(
  parameter int unsigned NUM_BOX        = 4,
  parameter int unsigned NUM_LINE       = 2,
  parameter bit          PER_BOX_IE     = 1'b1,
  parameter int unsigned CAP_SEM_SHARED = 3,
  parameter int unsigned CAP_SEM_ARB    = 2,
  parameter int unsigned CAP_DOORBELL   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [shmbox_pkg::ADDR_W-1:0] wr_addr,
  input  logic [shmbox_pkg::WORD_W-1:0] wr_data,
  input  logic                          rd_en,
  input  logic [shmbox_pkg::ADDR_W-1:0] rd_addr,
  output logic [shmbox_pkg::WORD_W-1:0] rd_data,
  output logic [NUM_LINE-1:0]           irq
);
  import shmbox_pkg::*;

  localparam logic [WORD_W-1:0] CAP_WORD = {12'h000, 4'(NUM_LINE), 4'(CAP_DOORBELL),
                                            4'(CAP_SEM_ARB), 4'(CAP_SEM_SHARED), 4'(NUM_BOX)};

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  dec_t wdec, rdec;
  assign wdec = decode(wr_addr, NUM_BOX, NUM_LINE);
  assign rdec = decode(rd_addr, NUM_BOX, NUM_LINE);

  logic wr_slot_hit;
  assign wr_slot_hit = wr_en && (wdec.sel == SEL_SLOT);

  logic [BOX_MAX-1:0][WORD_W-1:0] word_arr;
  logic [BOX_MAX-1:0]             ief_arr, iee_arr;
  logic [NUM_BOX-1:0]             full_vec, gfull, gempty;

  for (genvar i = 0; i < BOX_MAX; i++) begin : g_slot
    if (i < NUM_BOX) begin : g_live
      logic hit;
      assign hit = wr_slot_hit && (wdec.slot == 3'(i));

      shmbox_slot #(.PER_BOX_IE(PER_BOX_IE)) u_slot (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .word_we    (hit && (wdec.field == 2'd0)),
        .ief_we     (hit && (wdec.field == 2'd1)),
        .iee_we     (hit && (wdec.field == 2'd2)),
        .wdata      (wr_data),
        .word_q     (word_arr[i]),
        .gate_full  (gfull[i]),
        .gate_empty (gempty[i]),
        .ief_rd     (ief_arr[i]),
        .iee_rd     (iee_arr[i])
      );
      assign full_vec[i] = word_arr[i][FLAG_BIT];
    end else begin : g_pad
      assign word_arr[i] = '0;
      assign ief_arr[i]  = 1'b0;
      assign iee_arr[i]  = 1'b0;
    end
  end

  logic [NUM_LINE-1:0]             line_we;
  logic [STAT_W-1:0]               status_w;
  logic [NUM_LINE-1:0][STAT_W-1:0] line_en_w;

  for (genvar n = 0; n < NUM_LINE; n++) begin : g_lwe
    assign line_we[n] = wr_en && (wdec.sel == SEL_LINE) && (wdec.line == 4'(n));
  end

  shmbox_irq_agg #(.NUM_BOX(NUM_BOX), .NUM_LINE(NUM_LINE)) u_agg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .full_vec   (full_vec),
    .gate_full  (gfull),
    .gate_empty (gempty),
    .en_we      (line_we),
    .wdata      (wr_data[STAT_W-1:0]),
    .status     (status_w),
    .line_en    (line_en_w),
    .irq        (irq)
  );

  logic [LINE_MAX-1:0][STAT_W-1:0] line_pad;
  for (genvar n = 0; n < LINE_MAX; n++) begin : g_lpad
    if (n < NUM_LINE) begin : g_live
      assign line_pad[n] = line_en_w[n];
    end else begin : g_zero
      assign line_pad[n] = '0;
    end
  end

  logic [WORD_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rdec.sel)
      SEL_SLOT: begin
        case (rdec.field)
          2'd0:    rd_next = word_arr[rdec.slot];
          2'd1:    rd_next = {31'b0, ief_arr[rdec.slot]};
          2'd2:    rd_next = {31'b0, iee_arr[rdec.slot]};
          default: rd_next = '0;
        endcase
      end
      SEL_LINE:   rd_next = {16'b0, line_pad[rdec.line]};
      SEL_STATUS: rd_next = {16'b0, status_w};
      SEL_CAP:    rd_next = CAP_WORD;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_data <= '0;
    else if (rd_en)  rd_data <= rd_next;
  end
endmodule

// File: rtl/shmbox_hub_chk.sv
module shmbox_hub_chk #(
  parameter int unsigned NUM_BOX        = 4,
  parameter int unsigned NUM_LINE       = 2,
  parameter int unsigned CAP_SEM_SHARED = 3,
  parameter int unsigned CAP_SEM_ARB    = 2,
  parameter int unsigned CAP_DOORBELL   = 5
) (
  input logic                   clk,
  input logic                   rst_ni,
  input logic                   wr_en,
  input logic [11:0]            wr_addr,
  input logic [31:0]            wr_data,
  input logic                   rd_en,
  input logic [11:0]            rd_addr,
  input logic [31:0]            rd_data,
  input logic [15:0]            status,
  input logic [NUM_LINE-1:0][15:0] line_en,
  input logic [NUM_LINE-1:0]    irq
);
  localparam logic [7:0]  BMASK = 8'((1 << NUM_BOX) - 1);
  localparam logic [15:0] SMASK = {BMASK, BMASK};
  localparam logic [31:0] CAP_EXP = (32'(NUM_LINE) << 16) | (32'(CAP_DOORBELL) << 12) |
                                    (32'(CAP_SEM_ARB) << 8) | (32'(CAP_SEM_SHARED) << 4) |
                                    32'(NUM_BOX);

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    AST_FLAGGED_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_en && wr_addr == 12'(i * 32) && wr_data[31]) |=> status[8 + i]); // R2
    AST_ZERO_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_en && wr_addr == 12'(i * 32) && wr_data == 32'h0) |=> (status[i] && !status[8 + i])); // R3
    AST_FULL_EMPTY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
      status[i] != status[8 + i]); // R4
  end

  AST_UNBUILT_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (status & ~SMASK) == 16'h0); // R4
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == 12'h304) |=> $stable(status)); // R4

  for (genvar n = 0; n < NUM_LINE; n++) begin : g_line
    AST_IRQ_NEEDS_ENABLED_BIT: assert property (@(posedge clk) disable iff (!rst_ni)
      irq[n] |-> ((line_en[n] & status) != 16'h0)); // R6
    AST_LINE_EN_NO_GHOST_BITS: assert property (@(posedge clk) disable iff (!rst_ni)
      (line_en[n] & ~SMASK) == 16'h0); // R5
  end

  AST_CAP_READ_VALUE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && rd_addr == 12'h380) |=> (rd_data == CAP_EXP)); // R8
  AST_READ_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_data)); // R9
endmodule

bind shmbox_hub shmbox_hub_chk #(
  .NUM_BOX(NUM_BOX), .NUM_LINE(NUM_LINE), .CAP_SEM_SHARED(CAP_SEM_SHARED),
  .CAP_SEM_ARB(CAP_SEM_ARB), .CAP_DOORBELL(CAP_DOORBELL)
) u_chk (
  .clk(clk), .rst_ni(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .status(status_w),
  .line_en(line_en_w), .irq(irq)
);

// File: tb/shmbox_hub_tb.sv
`timescale 1ns/1ps
module shmbox_hub_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [11:0] wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  shmbox_hub u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {is_write, addr, data, expected read, expected irq, requirement}
  localparam int NV = 24;
  localparam logic [82:0] VEC [NV] = '{
    {1'b0, 12'h304, 32'h0, 32'h0000000F, 2'b00, 4'd4},  // R4 all vacant
    {1'b1, 12'h000, 32'h80001234, 32'h0, 2'b00, 4'd2},  // R2 fill slot 0
    {1'b0, 12'h000, 32'h0, 32'h80001234, 2'b00, 4'd2},  // R2
    {1'b0, 12'h304, 32'h0, 32'h0000010E, 2'b00, 4'd4},  // R4
    {1'b1, 12'h100, 32'h00000100, 32'h0, 2'b00, 4'd7},  // R7 gate still closed
    {1'b1, 12'h004, 32'h00000001, 32'h0, 2'b01, 4'd7},  // R7 open gate
    {1'b0, 12'h100, 32'h0, 32'h00000100, 2'b01, 4'd5},  // R5
    {1'b1, 12'h104, 32'hFFFFFFFF, 32'h0, 2'b11, 4'd6},  // R6
    {1'b0, 12'h104, 32'h0, 32'h00000F0F, 2'b11, 4'd5},  // R5 masked bits
    {1'b1, 12'h000, 32'h00000000, 32'h0, 2'b00, 4'd3},  // R3 drain
    {1'b0, 12'h000, 32'h0, 32'h00000000, 2'b00, 4'd3},  // R3
    {1'b1, 12'h048, 32'h00000001, 32'h0, 2'b10, 4'd7},  // R7 vacant gate slot 2
    {1'b0, 12'h048, 32'h0, 32'h00000001, 2'b10, 4'd7},  // R7
    {1'b1, 12'h304, 32'hFFFFFFFF, 32'h0, 2'b10, 4'd4},  // R4 write ignored
    {1'b0, 12'h304, 32'h0, 32'h0000000F, 2'b10, 4'd4},  // R4
    {1'b1, 12'h040, 32'h80000001, 32'h0, 2'b00, 4'd6},  // R6 condition gone
    {1'b0, 12'h040, 32'h0, 32'h80000001, 2'b00, 4'd2},  // R2
    {1'b1, 12'h380, 32'h00000000, 32'h0, 2'b00, 4'd8},  // R8 write ignored
    {1'b0, 12'h380, 32'h0, 32'h00025234, 2'b00, 4'd8},  // R8
    {1'b0, 12'h200, 32'h0, 32'h00000000, 2'b00, 4'd9},  // R9 unmapped
    {1'b1, 12'h060, 32'h7FFFFFFF, 32'h0, 2'b00, 4'd2},  // R2 no flag
    {1'b0, 12'h304, 32'h0, 32'h0000040B, 2'b00, 4'd2},  // R2
    {1'b1, 12'h044, 32'h00000001, 32'h0, 2'b10, 4'd7},  // R7 occupied gate slot 2
    {1'b0, 12'h044, 32'h0, 32'h00000001, 2'b10, 4'd7}   // R7
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(1, "irq after reset", {30'b0, irq}, 32'h0);
    do_read(12'h000, v); check(1, "slot0 after reset", v, 32'h0);
    do_read(12'h104, v); check(1, "line1 enable after reset", v, 32'h0);
    do_read(12'h008, v); check(1, "gate after reset", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [82:0] e;
      e = VEC[k];
      if (e[82]) do_write(e[81:70], e[69:38]);
      else begin
        do_read(e[81:70], v);
        check(int'(e[3:0]), $sformatf("vector %0d read", k), v, e[37:6]);
      end
      check(int'(e[3:0]), $sformatf("vector %0d irq", k), {30'b0, irq}, {30'b0, e[5:4]});
    end

    // R5 absent line address
    do_write(12'h108, 32'hFFFFFFFF);
    do_read(12'h108, v); check(5, "absent line enable", v, 32'h0);
    do_read(12'h100, v); check(5, "line0 untouched", v, 32'h00000100);

    // R6 level behaviour with slot 1 vacant
    do_write(12'h100, 32'h00000002);
    do_write(12'h028, 32'h00000001);
    check(6, "irq0 raised", {31'b0, irq[0]}, 32'h1);
    repeat (10) @(negedge clk);
    check(6, "irq0 held at level", {31'b0, irq[0]}, 32'h1);
    do_write(12'h020, 32'h80000000);
    check(6, "irq0 dropped", {31'b0, irq[0]}, 32'h0);

    // R9 read data holds while rd_en low
    do_read(12'h380, v);
    do_write(12'h060, 32'h80000005);
    repeat (3) @(negedge clk);
    check(9, "rd_data hold", rd_data, 32'h00025234);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(1, "irq during reset", {30'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(12'h040, v); check(1, "slot2 after mid reset", v, 32'h0);
    do_read(12'h044, v); check(1, "gate after mid reset", v, 32'h0);
    do_read(12'h100, v); check(1, "line0 after mid reset", v, 32'h0);
    do_read(12'h304, v); check(1, "status after mid reset", v, 32'h0000000F);
    check(1, "irq after mid reset", {30'b0, irq}, 32'h0);

    finish_run();
  end
endmodule